// File: doc/BRIEF.md
# Status Register Lock Controller

This block holds the protection configuration of a serial flash status register and decides, for every status write that reaches it, whether the new value may be stored. The register carries a protected-range code, a sector-granularity flag, a top/bottom flag, a complement flag, a register-protect flag and a permanent-lock flag. Commands arrive one per cycle as an opcode with a data byte. A write-enable command must come before each status write.

Three locks guard the settings, checked from strongest to weakest. The permanent lock can be set only at the end of a keyed unlock sequence, and only a hard reset clears it. The supply lock is raised by a dedicated command and is dropped by the next power cycle. The pin lock applies while the register-protect flag is set and the write-protect pin is driven low. A refused write changes nothing and produces a one-cycle reject pulse together with a cause code. An accepted write produces a one-cycle applied pulse.

The input `pwr_cycle` models a supply interruption. It clears only the volatile state: the supply lock, the write-enable latch and any progress through the unlock sequence. The register bits are treated as non-volatile and survive it. The input `rst_n` returns the block to its factory state.

Top module: `status_lock_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `sr_q` is 0x00, `pwr_locked` is 0, both pulses are 0 and `rej_cause` is 0.
- R2: Opcode 1 (status write) is acted on only if the write-enable latch was set earlier by opcode 0. Without the latch the write is dropped with neither pulse. Every status write acted on clears the latch, whether it is applied or refused.
- R3: Register layout with the default parameters: bits 2:0 are the range code, bit 3 the sector flag, bit 4 top/bottom, bit 5 complement, bit 6 register-protect, bit 7 permanent lock. An accepted write loads bits 6:0 from `cmd_data`, shows the new value on `sr_q` one cycle after the command, and raises `wr_applied` for that one cycle.
- R4: While bit 6 is 1 and `wp_n` is 0, a write that would change any of bits 6:0 is refused with cause 1. A write that leaves those bits unchanged is accepted.
- R5: With `wp_n` high, and with no supply or permanent lock in force, writes are accepted again even when bit 6 is set.
- R6: Opcode 3 sets `pwr_locked` one cycle later. While it is set, every status write is refused with cause 2.
- R7: A one-cycle `pwr_cycle` pulse clears `pwr_locked`, the write-enable latch and unlock progress, and leaves `sr_q` unchanged.
- R8: A write with bit 7 set is accepted only when it comes straight after NKEYS consecutive unlock commands (opcode 2) carrying keys KEY_SEED + i*KEY_STRIDE, taken modulo 256 (A5, E1, 1D with the defaults). Idle cycles do not break the sequence. Any other command, or a wrong key, starts the sequence over. A write with bit 7 set that has not been unlocked is refused with cause 4.
- R9: Once bit 7 is set it stays set, and every later write is refused with cause 3, across power cycles too. Only `rst_n` clears it.
- R10: A refused write leaves `sr_q` unchanged and raises `wr_rejected` for one cycle, with the cause on `rej_cause` in that same cycle. `wr_applied` and `wr_rejected` are never high together.
- R11: When several locks apply at once, the cause reported is the first of these that applies: permanent (3), supply (2), pin (1), missing unlock sequence (4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset to factory state, active low |
| pwr_cycle | input | 1 | Supply-interruption pulse; clears volatile state only |
| wp_n | input | 1 | Write-protect pin, low means protect |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 2 | Opcode: 0 write-enable, 1 status write, 2 unlock key, 3 supply lock |
| cmd_data | input | CMD_W (8) | New register value or key byte |
| sr_q | output | SR_W (8) | Current status register |
| pwr_locked | output | 1 | Supply lock is in force |
| wr_applied | output | 1 | One-cycle pulse: status write accepted |
| wr_rejected | output | 1 | One-cycle pulse: status write refused |
| rej_cause | output | 3 | Reason for the refusal, valid together with `wr_rejected` |

## Verification
Some properties are checked by assertions on every cycle: the permanent-lock bit never falls, the register stays frozen under the permanent lock and under the supply lock, the two pulses never coincide, each pulse follows a status write that had the latch set, a pin-guarded change is always refused, and the permanent bit only ever rises on an unlocked write. Other behaviour can only be shown by the bench's scenarios: the exact key values and their order, aborts caused by stray or wrong commands, the cause chosen when several locks apply at once, and the register surviving a power cycle while the supply lock is lost.

// File: rtl/srlk_pkg.sv
package srlk_pkg;

   typedef enum logic [1:0] {
      OP_WREN   = 2'd0,
      OP_WRSR   = 2'd1,
      OP_UNLOCK = 2'd2,
      OP_LOCKDN = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      RC_NONE = 3'd0,
      RC_PIN  = 3'd1,
      RC_PWR  = 3'd2,
      RC_PERM = 3'd3,
      RC_SEQ  = 3'd4
   } cause_e;

   // fixed flag count above the range code: sector, top, complement, protect, lock
   localparam int FLAG_BITS = 5;

endpackage

// File: rtl/srlk_keyseq.sv
module srlk_keyseq
   import srlk_pkg::*;
#(
   parameter int          NKEYS      = 3,
   parameter int          KEY_W      = 8,
   parameter logic [7:0]  KEY_SEED   = 8'hA5,
   parameter logic [7:0]  KEY_STRIDE = 8'h3C
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_cycle,
   input  logic             cmd_valid,
   input  op_e              cmd_op,
   input  logic [KEY_W-1:0] key_in,
   output logic             armed
);

   localparam int CW = $clog2(NKEYS + 1);

   logic [CW-1:0]    cnt;
   logic [KEY_W-1:0] want;

   always_comb begin
      want = KEY_W'(int'(KEY_SEED) + int'(KEY_STRIDE) * int'(cnt));
   end

   assign armed = (cnt == CW'(NKEYS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (pwr_cycle) begin
         cnt <= '0;
      end else if (cmd_valid) begin
         if (cmd_op == OP_UNLOCK && !armed && key_in == want)
            cnt <= cnt + CW'(1);
         else
            cnt <= '0;
      end
   end

   assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(NKEYS));

   assert_cycle_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_cycle |=> !armed);

endmodule

// File: rtl/srlk_arbiter.sv
module srlk_arbiter
   import srlk_pkg::*;
#(
   parameter int NBP           = 3,
   parameter bit PIN_GUARD_ALL = 1'b1
) (
   input  logic [NBP+FLAG_BITS-1:0] cur,
   input  logic [NBP+FLAG_BITS-1:0] wdata,
   input  logic                     wp_n,
   input  logic                     pwr_lock,
   input  logic                     armed,
   output cause_e                   cause,
   output logic [NBP+FLAG_BITS-1:0] nxt
);

   localparam int SR_W  = NBP + FLAG_BITS;
   localparam int B_SRP = NBP + 3;
   localparam int B_PL  = NBP + 4;

   logic [SR_W-1:0] guard;
   logic            touches;

   generate
      if (PIN_GUARD_ALL) begin : g_guard_all
         assign guard = {1'b0, {(SR_W-1){1'b1}}};
      end else begin : g_guard_range
         assign guard = {{(SR_W-NBP-1){1'b0}}, {(NBP+1){1'b1}}};
      end
   endgenerate

   assign touches = |((wdata ^ cur) & guard);

   always_comb begin
      if (cur[B_PL])
         cause = RC_PERM;
      else if (pwr_lock)
         cause = RC_PWR;
      else if (cur[B_SRP] && !wp_n && touches)
         cause = RC_PIN;
      else if (wdata[B_PL] && !armed)
         cause = RC_SEQ;
      else
         cause = RC_NONE;
   end

   assign nxt = {wdata[B_PL] & armed, wdata[SR_W-2:0]};

endmodule

// File: rtl/srlk_state.sv
module srlk_state
   import srlk_pkg::*;
#(
   parameter int NBP = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     pwr_cycle,
   input  logic                     cmd_valid,
   input  op_e                      cmd_op,
   input  logic                     wp_n,
   input  logic [NBP+FLAG_BITS-1:0] wdata,
   input  cause_e                   cause,
   input  logic [NBP+FLAG_BITS-1:0] nxt,
   output logic [NBP+FLAG_BITS-1:0] sr,
   output logic                     pwr_lock,
   output logic                     applied,
   output logic                     rejected,
   output cause_e                   rej_cause
);

   localparam int SR_W  = NBP + FLAG_BITS;
   localparam int B_SRP = NBP + 3;
   localparam int B_PL  = NBP + 4;
   localparam logic [SR_W-1:0] RANGE_MASK = SR_W'((1 << (NBP + 1)) - 1);

   logic wel;
   logic wr_fire;

   assign wr_fire = cmd_valid && cmd_op == OP_WRSR && wel && !pwr_cycle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr        <= '0;
         pwr_lock  <= 1'b0;
         wel       <= 1'b0;
         applied   <= 1'b0;
         rejected  <= 1'b0;
         rej_cause <= RC_NONE;
      end else begin
         applied   <= 1'b0;
         rejected  <= 1'b0;
         rej_cause <= RC_NONE;
         if (pwr_cycle) begin
            pwr_lock <= 1'b0;
            wel      <= 1'b0;
         end else if (cmd_valid) begin
            unique case (cmd_op)
               OP_WREN:   wel <= 1'b1;
               OP_LOCKDN: pwr_lock <= 1'b1;
               OP_WRSR: begin
                  wel <= 1'b0;
                  if (wel) begin
                     if (cause == RC_NONE) begin
                        sr      <= nxt;
                        applied <= 1'b1;
                     end else begin
                        rejected  <= 1'b1;
                        rej_cause <= cause;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assert_perm_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sr[B_PL] |=> sr[B_PL]);

   assert_perm_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sr[B_PL] |=> $stable(sr));

   assert_supply_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_lock && !pwr_cycle) |=> $stable(sr));

   assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(applied && rejected));

   assert_pulse_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (applied || rejected) |-> $past(wr_fire));

   assert_latch_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |=> !wel);

   assert_pin_refuses_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && sr[B_SRP] && !wp_n && |((wdata ^ sr) & RANGE_MASK)) |=> rejected);

   assert_reject_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rejected |-> $stable(sr));

endmodule

// File: rtl/status_lock_ctrl.sv
module status_lock_ctrl
   import srlk_pkg::*;
#(
   parameter int         NBP           = 3,
   parameter int         NKEYS         = 3,
   parameter int         KEY_W         = 8,
   parameter logic [7:0] KEY_SEED      = 8'hA5,
   parameter logic [7:0] KEY_STRIDE    = 8'h3C,
   parameter bit         PIN_GUARD_ALL = 1'b1,
   localparam int        SR_W          = NBP + FLAG_BITS,
   localparam int        CMD_W         = (SR_W > KEY_W) ? SR_W : KEY_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_cycle,
   input  logic             wp_n,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd_op,
   input  logic [CMD_W-1:0] cmd_data,
   output logic [SR_W-1:0]  sr_q,
   output logic             pwr_locked,
   output logic             wr_applied,
   output logic             wr_rejected,
   output logic [2:0]       rej_cause
);

   localparam int B_PL = NBP + 4;

   generate
      if (NBP < 1 || NBP > 8) begin : g_bad_nbp
         $error("status_lock_ctrl: NBP must lie in 1..8");
      end
      if (NKEYS < 1 || NKEYS > 8) begin : g_bad_nkeys
         $error("status_lock_ctrl: NKEYS must lie in 1..8");
      end
      if (KEY_W < 1 || KEY_W > 8) begin : g_bad_keyw
         $error("status_lock_ctrl: KEY_W must lie in 1..8");
      end
   endgenerate

   op_e             op;
   logic            armed;
   cause_e          cause;
   cause_e          cause_q;
   logic [SR_W-1:0] nxt;

   assign op        = op_e'(cmd_op);
   assign rej_cause = cause_q;

   srlk_keyseq #(
      .NKEYS(NKEYS), .KEY_W(KEY_W), .KEY_SEED(KEY_SEED), .KEY_STRIDE(KEY_STRIDE)
   ) u_keys (
      .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle), .cmd_valid(cmd_valid),
      .cmd_op(op), .key_in(cmd_data[KEY_W-1:0]), .armed(armed)
   );

   srlk_arbiter #(.NBP(NBP), .PIN_GUARD_ALL(PIN_GUARD_ALL)) u_arb (
      .cur(sr_q), .wdata(cmd_data[SR_W-1:0]), .wp_n(wp_n), .pwr_lock(pwr_locked),
      .armed(armed), .cause(cause), .nxt(nxt)
   );

   srlk_state #(.NBP(NBP)) u_state (
      .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle), .cmd_valid(cmd_valid),
      .cmd_op(op), .wp_n(wp_n), .wdata(cmd_data[SR_W-1:0]), .cause(cause),
      .nxt(nxt), .sr(sr_q), .pwr_lock(pwr_locked), .applied(wr_applied),
      .rejected(wr_rejected), .rej_cause(cause_q)
   );

   assert_perm_needs_keys_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sr_q[B_PL]) |-> $past(cmd_valid && op == OP_WRSR && armed));

   assert_cause_with_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rej_cause != 3'd0) |-> wr_rejected);

endmodule

// File: tb/status_lock_ctrl_test.sv
`timescale 1ns/1ps
module status_lock_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_cycle = 1'b0;
   logic       wp_n = 1'b1;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_op = 2'd0;
   logic [7:0] cmd_data = 8'h00;
   logic [7:0] sr_q;
   logic       pwr_locked, wr_applied, wr_rejected;
   logic [2:0] rej_cause;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 1'b0;

   always #5 clk = ~clk;

   status_lock_ctrl uut (
      .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle), .wp_n(wp_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
      .sr_q(sr_q), .pwr_locked(pwr_locked), .wr_applied(wr_applied),
      .wr_rejected(wr_rejected), .rej_cause(rej_cause)
   );

   localparam logic [1:0] WE = 2'd0, WR = 2'd1, UK = 2'd2, LD = 2'd3;

   // {op, data, wp_n, exp sr, exp pwr, exp applied, exp rejected, exp cause}
   localparam int NV = 21;
   localparam logic [24:0] VEC [NV] = '{
      {WE, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0},  // R2 latch set
      {WR, 8'h45, 1'b1, 8'h45, 1'b0, 1'b1, 1'b0, 3'd0},  // R3 accepted
      {WR, 8'h07, 1'b1, 8'h45, 1'b0, 1'b0, 1'b0, 3'd0},  // R2 no latch
      {WE, 8'h00, 1'b0, 8'h45, 1'b0, 1'b0, 1'b0, 3'd0},
      {WR, 8'h07, 1'b0, 8'h45, 1'b0, 1'b0, 1'b1, 3'd1},  // R4 pin refuses
      {WR, 8'h45, 1'b0, 8'h45, 1'b0, 1'b0, 1'b0, 3'd0},  // R2 latch cleared by refusal
      {WE, 8'h00, 1'b0, 8'h45, 1'b0, 1'b0, 1'b0, 3'd0},
      {WR, 8'h45, 1'b0, 8'h45, 1'b0, 1'b1, 1'b0, 3'd0},  // R4 unchanged value passes
      {WE, 8'h00, 1'b1, 8'h45, 1'b0, 1'b0, 1'b0, 3'd0},
      {WR, 8'h13, 1'b1, 8'h13, 1'b0, 1'b1, 1'b0, 3'd0},  // R5 pin high
      {WE, 8'h00, 1'b1, 8'h13, 1'b0, 1'b0, 1'b0, 3'd0},
      {WR, 8'h93, 1'b1, 8'h13, 1'b0, 1'b0, 1'b1, 3'd4},  // R8 no keys
      {WE, 8'h00, 1'b1, 8'h13, 1'b0, 1'b0, 1'b0, 3'd0},
      {UK, 8'hA5, 1'b1, 8'h13, 1'b0, 1'b0, 1'b0, 3'd0},
      {UK, 8'hE1, 1'b1, 8'h13, 1'b0, 1'b0, 1'b0, 3'd0},
      {WE, 8'h00, 1'b1, 8'h13, 1'b0, 1'b0, 1'b0, 3'd0},  // R8 stray command aborts
      {UK, 8'h1D, 1'b1, 8'h13, 1'b0, 1'b0, 1'b0, 3'd0},
      {WR, 8'h93, 1'b1, 8'h13, 1'b0, 1'b0, 1'b1, 3'd4},  // R8 aborted sequence
      {LD, 8'h00, 1'b1, 8'h13, 1'b1, 1'b0, 1'b0, 3'd0},  // R6 supply lock
      {WE, 8'h00, 1'b1, 8'h13, 1'b1, 1'b0, 1'b0, 3'd0},
      {WR, 8'h22, 1'b1, 8'h13, 1'b1, 1'b0, 1'b1, 3'd2}   // R6 refused
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] snap();
      return {18'd0, sr_q, pwr_locked, wr_applied, wr_rejected, rej_cause};
   endfunction

   function automatic logic [31:0] want(input logic [7:0] s, input logic p,
                                        input logic a, input logic r, input logic [2:0] c);
      return {18'd0, s, p, a, r, c};
   endfunction

   // drive at a falling edge, let one rising edge pass, return at the next falling edge
   task automatic issue(input logic [1:0] op, input logic [7:0] d, input logic wp);
      cmd_op = op; cmd_data = d; wp_n = wp; cmd_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic power_cycle();
      pwr_cycle = 1'b1;
      @(posedge clk);
      @(negedge clk);
      pwr_cycle = 1'b0;
   endtask

   task automatic idle();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 in reset", snap(), want(8'h00, 0, 0, 0, 3'd0));
      rst_n = 1'b1;
      idle();
      chk("R1 after release", snap(), want(8'h00, 0, 0, 0, 3'd0));

      for (int i = 0; i < NV; i++) begin
         automatic logic [24:0] v = VEC[i];
         issue(v[24:23], v[22:15], v[14]);
         chk($sformatf("vector %0d (R2..R6,R8,R10)", i), snap(),
             want(v[13:6], v[5], v[4], v[3], v[2:0]));
      end

      // R7: power cycle drops supply lock and latch, keeps bits
      issue(WE, 8'h00, 1'b1);
      power_cycle();
      chk("R7 supply lock cleared, bits kept", snap(), want(8'h13, 0, 0, 0, 3'd0));
      issue(WR, 8'h22, 1'b1);
      chk("R7 latch cleared by power cycle", snap(), want(8'h13, 0, 0, 0, 3'd0));

      // R11: supply lock outranks pin lock
      issue(WE, 8'h00, 1'b1);
      issue(WR, 8'h53, 1'b1);
      chk("R3 set protect flag", snap(), want(8'h53, 0, 1, 0, 3'd0));
      issue(LD, 8'h00, 1'b0);
      issue(WE, 8'h00, 1'b0);
      issue(WR, 8'h13, 1'b0);
      chk("R11 supply over pin", snap(), want(8'h53, 1, 0, 1, 3'd2));
      power_cycle();
      issue(WE, 8'h00, 1'b0);
      issue(WR, 8'h13, 1'b0);
      chk("R4 pin lock after power cycle", snap(), want(8'h53, 0, 0, 1, 3'd1));
      issue(WE, 8'h00, 1'b1);
      issue(WR, 8'h13, 1'b1);
      chk("R5 pin high re-enables", snap(), want(8'h13, 0, 1, 0, 3'd0));

      // R8: wrong key restarts the sequence
      issue(WE, 8'h00, 1'b1);
      issue(UK, 8'hA5, 1'b1);
      issue(UK, 8'h00, 1'b1);
      issue(UK, 8'hE1, 1'b1);
      issue(UK, 8'h1D, 1'b1);
      issue(WR, 8'h93, 1'b1);
      chk("R8 wrong key", snap(), want(8'h13, 0, 0, 1, 3'd4));

      // R8: correct sequence with an idle gap commits the lock
      issue(WE, 8'h00, 1'b1);
      issue(UK, 8'hA5, 1'b1);
      idle();
      issue(UK, 8'hE1, 1'b1);
      issue(UK, 8'h1D, 1'b1);
      issue(WR, 8'h93, 1'b1);
      chk("R8 keyed commit", snap(), want(8'h93, 0, 1, 0, 3'd0));
      idle();
      chk("R10 pulse lasts one cycle", snap(), want(8'h93, 0, 0, 0, 3'd0));

      // R11 / R9: permanent outranks supply, survives power cycle
      issue(LD, 8'h00, 1'b1);
      issue(WE, 8'h00, 1'b1);
      issue(WR, 8'h00, 1'b1);
      chk("R11 permanent over supply", snap(), want(8'h93, 1, 0, 1, 3'd3));
      power_cycle();
      issue(WE, 8'h00, 1'b1);
      issue(WR, 8'h00, 1'b1);
      chk("R9 permanent across power cycle", snap(), want(8'h93, 0, 0, 1, 3'd3));

      // R9 / R1: only hard reset clears it
      rst_n = 1'b0;
      idle();
      chk("R9 hard reset clears", snap(), want(8'h00, 0, 0, 0, 3'd0));
      rst_n = 1'b1;
      idle();

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end

endmodule